// File: doc/BRIEF.md
# SDRAM Command Sequencer with Refresh

This block sits between a simple host request port and a four-bank, 16-bit-wide synchronous DRAM. It converts single-word read and write requests into the device's command stream and handles everything the memory needs in order to work. After reset it brings the device up: a power-up wait, a precharge of every bank, two refresh cycles, then a mode register load. It keeps the cells alive by issuing an auto refresh at a fixed clock interval, set from a budget of 4096 refreshes per 64 ms. Every access is closed-page: it opens a row, then issues a single read or write with auto-precharge, so no row stays open between requests.

The host holds `reqValid`, `reqWrite` and a 22-bit word address until `reqAck` is seen. The acknowledge is raised on the same cycle the read or write command appears on the pins. Every delay (row-to-column, row active time, row cycle, precharge, refresh cycle, mode-load gap, power-up wait and refresh interval) is a clock-count parameter. The outputs are registered, and the data bus is handled elsewhere.

Top module: `sdram_seq`

## Requirements
- R1: While `rstN` is low, `cke` is low, `csN` is high, and `reqAck` and `initDone` are low. After release, the pins show NOP (`csN` low, `rasN`/`casN`/`weN` high) for at least INIT_WAIT cycles before the first command.
- R2: Commands are encoded on {csN,rasN,casN,weN} as follows: NOP 0111, activate 0011, read 0101, write 0100, precharge 0010, auto refresh 0001, mode load 0000. At most one command is issued per cycle, and `cke` is high for every command.
- R3: Initialization runs in this order: precharge with A10 high (all banks); refresh T_RP cycles later; a second refresh T_RFC cycles after that; a mode load T_RFC cycles later still, with A equal to MODE_WORD and BA equal to 0.
- R4: No command follows a mode load within T_MRD cycles. `initDone` rises no earlier than T_MRD cycles after the mode load.
- R5: The address maps as bank = reqAddr[21:20], row = reqAddr[19:8], column = reqAddr[7:0]. Activate carries the bank on BA and the row on A11..A0. Exactly T_RCD cycles later, read or write carries the same bank on BA, the column on A7..A0, A10 high (auto-precharge), and A11, A9 and A8 low.
- R6: `reqAck` is high for exactly one cycle per request, on the cycle the read or write command is on the pins, and at no other time.
- R7: Any activate or refresh that follows an activate is at least T_RC cycles after it.
- R8: After an auto refresh, no command is issued for T_RFC cycles.
- R9: With no requests, refreshes are exactly REF_INTERVAL cycles apart. Under continuous requests, a due refresh is issued before the next activate, so refreshes are never more than REF_INTERVAL + T_RC cycles apart.
- R10: A request presented before initialization finishes is not served until `initDone` is high, and it does not alter the initialization sequence.
- R11: `reqWrite` chooses between a write command (1) and a read command (0). The flag is captured with the activate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request pending; hold until reqAck |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 22 | Word address {bank, row, column} |
| reqAck | output | 1 | One-cycle acknowledge, aligned with the read/write command |
| initDone | output | 1 | Initialization sequence complete |
| cke | output | 1 | Clock enable to the memory |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 12 | Multiplexed row/column/opcode address |

## Verification
The embedded assertions check these properties on every cycle: the pin-level spacing rules (mode-load gap, refresh cycle time, precharge time, row-to-column delay, row cycle time), the auto-precharge bit on every column command, single-command issue, and that the acknowledge only ever coincides with a column command. The bench scenarios are needed for the rest. These are the order and operands of the start-up sequence, the mapping of address fields onto BA and A, the read/write selection, the exact refresh period when idle, and refresh being interleaved under a continuous request stream. They also cover a request held across reset release being deferred until initialization completes.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // one strobe per command kind, driven by control, consumed by datapath
  typedef struct packed {
    logic doPreAll;
    logic doRefresh;
    logic doMode;
    logic doAct;
    logic doRw;
  } seqStrobe_t;

  // {rasN, casN, weN} patterns with csN low
  localparam logic [2:0] RCW_NOP = 3'b111;
  localparam logic [2:0] RCW_ACT = 3'b011;
  localparam logic [2:0] RCW_RD  = 3'b101;
  localparam logic [2:0] RCW_WR  = 3'b100;
  localparam logic [2:0] RCW_PRE = 3'b010;
  localparam logic [2:0] RCW_REF = 3'b001;
  localparam logic [2:0] RCW_MRS = 3'b000;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int INIT_WAIT    = 26600,
  parameter int REF_INTERVAL = 2075,
  parameter int T_RCD        = 3,
  parameter int T_RAS        = 6,
  parameter int T_RC         = 9,
  parameter int T_RP         = 3,
  parameter int T_RFC        = 9,
  parameter int T_MRD        = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output seqStrobe_t strobe,
  output logic       initDone
);

  // closing tail after the column command: covers both row cycle and active+precharge
  localparam int ACC_TAIL = maxOf(T_RC - T_RCD, T_RAS - T_RCD + T_RP);
  localparam int WAIT_MAX = maxOf(maxOf(INIT_WAIT, ACC_TAIL),
                                  maxOf(maxOf(T_RFC, T_RCD), maxOf(T_RP, T_MRD)));
  localparam int HOLD_W   = $clog2(WAIT_MAX + 1);
  localparam int REF_W    = $clog2(REF_INTERVAL + 1);

  typedef enum logic [2:0] {
    ST_HOLD, ST_PREALL, ST_REF1, ST_REF2, ST_MODE, ST_IDLE, ST_RW
  } state_t;

  state_t            state, resume, after;
  logic [HOLD_W-1:0] holdCnt;
  logic [REF_W-1:0]  refCnt;
  logic              refPending;
  logic              issuing;
  int                gap;
  logic              refWrap;

  assign refWrap = initDone && (refCnt == REF_W'(REF_INTERVAL - 1));

  always_comb begin
    strobe  = '0;
    issuing = 1'b0;
    gap     = 0;
    after   = state;
    case (state)
      ST_PREALL: begin strobe.doPreAll  = 1'b1; issuing = 1'b1; gap = T_RP;  after = ST_REF1; end
      ST_REF1:   begin strobe.doRefresh = 1'b1; issuing = 1'b1; gap = T_RFC; after = ST_REF2; end
      ST_REF2:   begin strobe.doRefresh = 1'b1; issuing = 1'b1; gap = T_RFC; after = ST_MODE; end
      ST_MODE:   begin strobe.doMode    = 1'b1; issuing = 1'b1; gap = T_MRD; after = ST_IDLE; end
      ST_IDLE: begin
        if (refPending) begin
          strobe.doRefresh = 1'b1; issuing = 1'b1; gap = T_RFC; after = ST_IDLE;
        end else if (reqValid) begin
          strobe.doAct = 1'b1; issuing = 1'b1; gap = T_RCD; after = ST_RW;
        end
      end
      ST_RW:     begin strobe.doRw = 1'b1; issuing = 1'b1; gap = ACC_TAIL; after = ST_IDLE; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_HOLD;
      holdCnt  <= HOLD_W'(INIT_WAIT - 1);
      resume   <= ST_PREALL;
      initDone <= 1'b0;
    end else begin
      if (state == ST_HOLD) begin
        if (holdCnt == '0) state <= resume;
        else               holdCnt <= holdCnt - 1'b1;
      end else if (issuing) begin
        if (gap <= 1) begin
          state <= after;
        end else begin
          state   <= ST_HOLD;
          holdCnt <= HOLD_W'(gap - 2);
          resume  <= after;
        end
      end
      if (state == ST_IDLE) initDone <= 1'b1;
    end
  end

  // refresh budget counter, runs once initialization is finished
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt     <= '0;
      refPending <= 1'b0;
    end else begin
      if (strobe.doRefresh && state == ST_IDLE) refPending <= 1'b0;
      if (initDone) begin
        if (refWrap) begin
          refCnt     <= '0;
          refPending <= 1'b1;
        end else begin
          refCnt <= refCnt + 1'b1;
        end
      end
    end
  end

  // R2
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  // R9
  ref_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refPending && state == ST_IDLE) |-> !strobe.doAct);

endmodule

// File: rtl/sdram_seq_dp.sv
module sdram_seq_dp
  import sdram_seq_pkg::*;
#(
  parameter int              BANK_W    = 2,
  parameter int              ROW_W     = 12,
  parameter int              COL_W     = 8,
  parameter int              ADDR_W    = 12,
  parameter logic [11:0]     MODE_WORD = 12'h030,
  parameter int              T_RCD     = 3,
  parameter int              T_RC      = 9,
  parameter int              T_RP      = 3,
  parameter int              T_RFC     = 9,
  parameter int              T_MRD     = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  seqStrobe_t                      strobe,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   reqAddr,
  input  logic                            reqWrite,
  output logic                            reqAck,
  output logic                            cke,
  output logic                            csN,
  output logic                            rasN,
  output logic                            casN,
  output logic                            weN,
  output logic [BANK_W-1:0]               ba,
  output logic [ADDR_W-1:0]               addr
);

  localparam int REQ_W  = BANK_W + ROW_W + COL_W;
  localparam int AP_BIT = 10;
  localparam int CAP    = maxOf(maxOf(T_RC, T_RFC), maxOf(maxOf(T_RP, T_MRD), T_RCD)) + 1;
  localparam int GAP_W  = $clog2(CAP + 1);

  logic [BANK_W-1:0] bankQ;
  logic [COL_W-1:0]  colQ;
  logic              writeQ;
  logic [ADDR_W-1:0] rowAddr, rwAddr, allAddr;

  always_comb begin
    rowAddr = '0;
    rowAddr[ROW_W-1:0] = reqAddr[COL_W +: ROW_W];
    rwAddr = '0;
    rwAddr[COL_W-1:0] = colQ;
    rwAddr[AP_BIT] = 1'b1;
    allAddr = '0;
    allAddr[AP_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cke    <= 1'b0;
      csN    <= 1'b1;
      {rasN, casN, weN} <= RCW_NOP;
      ba     <= '0;
      addr   <= '0;
      reqAck <= 1'b0;
      bankQ  <= '0;
      colQ   <= '0;
      writeQ <= 1'b0;
    end else begin
      cke    <= 1'b1;
      csN    <= 1'b0;
      reqAck <= 1'b0;
      ba     <= '0;
      addr   <= '0;
      {rasN, casN, weN} <= RCW_NOP;
      if (strobe.doPreAll) begin
        {rasN, casN, weN} <= RCW_PRE;
        addr <= allAddr;
      end else if (strobe.doRefresh) begin
        {rasN, casN, weN} <= RCW_REF;
      end else if (strobe.doMode) begin
        {rasN, casN, weN} <= RCW_MRS;
        addr <= ADDR_W'(MODE_WORD);
      end else if (strobe.doAct) begin
        {rasN, casN, weN} <= RCW_ACT;
        ba     <= reqAddr[REQ_W-1 -: BANK_W];
        addr   <= rowAddr;
        bankQ  <= reqAddr[REQ_W-1 -: BANK_W];
        colQ   <= reqAddr[COL_W-1:0];
        writeQ <= reqWrite;
      end else if (strobe.doRw) begin
        {rasN, casN, weN} <= writeQ ? RCW_WR : RCW_RD;
        ba     <= bankQ;
        addr   <= rwAddr;
        reqAck <= 1'b1;
      end
    end
  end

  // pin-level spacing trackers for the assertions below
  logic [2:0]       pinRcw, lastRcw;
  logic             isCmd, isRw, actSeen;
  logic [GAP_W-1:0] sinceCmd, sinceAct;

  assign pinRcw = {rasN, casN, weN};
  assign isCmd  = !csN && (pinRcw != RCW_NOP);
  assign isRw   = !csN && (pinRcw == RCW_RD || pinRcw == RCW_WR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastRcw  <= RCW_NOP;
      sinceCmd <= GAP_W'(CAP);
      sinceAct <= GAP_W'(CAP);
      actSeen  <= 1'b0;
    end else begin
      if (isCmd) begin
        lastRcw  <= pinRcw;
        sinceCmd <= GAP_W'(1);
      end else if (sinceCmd < GAP_W'(CAP)) begin
        sinceCmd <= sinceCmd + 1'b1;
      end
      if (isCmd && pinRcw == RCW_ACT) begin
        sinceAct <= GAP_W'(1);
        actSeen  <= 1'b1;
      end else if (sinceAct < GAP_W'(CAP)) begin
        sinceAct <= sinceAct + 1'b1;
      end
    end
  end

  // R6
  ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> isRw);

  // R5
  auto_pre_chk: assert property (@(posedge clk) disable iff (!rstN)
    isRw |-> addr[AP_BIT]);

  // R5
  rcd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isCmd && lastRcw == RCW_ACT) |-> (isRw && sinceCmd == GAP_W'(T_RCD)));

  // R4
  mode_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isCmd && lastRcw == RCW_MRS) |-> (sinceCmd >= GAP_W'(T_MRD)));

  // R8
  ref_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isCmd && lastRcw == RCW_REF) |-> (sinceCmd >= GAP_W'(T_RFC)));

  // R3
  pre_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isCmd && lastRcw == RCW_PRE) |-> (sinceCmd >= GAP_W'(T_RP)));

  // R7
  row_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actSeen && !csN && (pinRcw == RCW_ACT || pinRcw == RCW_REF)) |-> (sinceAct >= GAP_W'(T_RC)));

endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdram_seq_pkg::*;
#(
  parameter int          BANK_W       = 2,
  parameter int          ROW_W        = 12,
  parameter int          COL_W        = 8,
  parameter int          ADDR_W       = 12,
  parameter logic [11:0] MODE_WORD    = 12'h030,
  parameter int          INIT_WAIT    = 26600,
  parameter int          REF_INTERVAL = 2075,
  parameter int          T_RCD        = 3,
  parameter int          T_RAS        = 6,
  parameter int          T_RC         = 9,
  parameter int          T_RP         = 3,
  parameter int          T_RFC        = 9,
  parameter int          T_MRD        = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  logic                          reqWrite,
  input  logic [BANK_W+ROW_W+COL_W-1:0] reqAddr,
  output logic                          reqAck,
  output logic                          initDone,
  output logic                          cke,
  output logic                          csN,
  output logic                          rasN,
  output logic                          casN,
  output logic                          weN,
  output logic [BANK_W-1:0]             ba,
  output logic [ADDR_W-1:0]             addr
);

  seqStrobe_t strobe;

  sdram_seq_ctrl #(
    .INIT_WAIT(INIT_WAIT), .REF_INTERVAL(REF_INTERVAL),
    .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP),
    .T_RFC(T_RFC), .T_MRD(T_MRD)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .strobe(strobe), .initDone(initDone)
  );

  sdram_seq_dp #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
    .MODE_WORD(MODE_WORD), .T_RCD(T_RCD), .T_RC(T_RC), .T_RP(T_RP),
    .T_RFC(T_RFC), .T_MRD(T_MRD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqAck(reqAck),
    .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .addr(addr)
  );

endmodule

// File: tb/sdram_seq_tb.sv
module sdram_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int INIT_WAIT  = 12;
  localparam int REF_INT    = 80;
  localparam int T_RCD      = 3;
  localparam int T_RC       = 9;
  localparam int T_RP       = 3;
  localparam int T_RFC      = 7;
  localparam int T_MRD      = 2;
  localparam logic [11:0] MODE = 12'h030;
  localparam int LOG_N      = 1024;

  localparam logic [2:0] K_ACT = 3'b011, K_RD = 3'b101, K_WR = 3'b100,
                         K_PRE = 3'b010, K_REF = 3'b001, K_MRS = 3'b000;

  logic        clk = 1'b0;
  logic        rstN, reqValid, reqWrite;
  logic [21:0] reqAddr;
  logic        reqAck, initDone, cke, csN, rasN, casN, weN;
  logic [1:0]  ba;
  logic [11:0] addr;

  sdram_seq #(
    .INIT_WAIT(INIT_WAIT), .REF_INTERVAL(REF_INT), .T_RCD(T_RCD), .T_RC(T_RC),
    .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .MODE_WORD(MODE)
  ) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqAck(reqAck), .initDone(initDone), .cke(cke),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .ba(ba), .addr(addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;
  int nLog    = 0;
  int ackTotal = 0;
  int strayAck = 0;
  int ckeLow  = 0;
  int          logCyc [LOG_N];
  logic [2:0]  logK   [LOG_N];
  logic [1:0]  logBa  [LOG_N];
  logic [11:0] logA   [LOG_N];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN) begin
      if (!csN && {rasN, casN, weN} != 3'b111) begin
        if (!cke) ckeLow++;
        if (nLog < LOG_N) begin
          logCyc[nLog] = cyc; logK[nLog] = {rasN, casN, weN};
          logBa[nLog] = ba;   logA[nLog] = addr;
          nLog++;
        end
      end
      if (reqAck) begin
        ackTotal++;
        if (!(!csN && (rasN && !casN))) strayAck++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  // waits for reqAck, then verifies the activate/column pair just issued
  task automatic awaitAck(input bit wr, input logic [21:0] a, input bit keepValid,
                          input logic [21:0] nextA);
    int n = 0;
    while (!reqAck && n < 400) begin @(negedge clk); n++; end
    #1;
    if (!keepValid) reqValid = 1'b0;
    else reqAddr = nextA;
    check(reqAck, "R6 ack seen", reqAck, 1);
    begin
      int k = nLog - 1;
      check(logK[k] == (wr ? K_WR : K_RD), "R11 column cmd kind", logK[k], wr ? K_WR : K_RD);
      check(logBa[k] == a[21:20], "R5 column bank", logBa[k], a[21:20]);
      check(logA[k] == {4'b0100, a[7:0]}, "R5 column addr+A10", logA[k], {4'b0100, a[7:0]});
      check(logK[k-1] == K_ACT, "R5 activate before column", logK[k-1], K_ACT);
      check(logBa[k-1] == a[21:20] && logA[k-1] == a[19:8], "R5 activate bank/row",
            {logBa[k-1], logA[k-1]}, {a[21:20], a[19:8]});
      check(logCyc[k] - logCyc[k-1] == T_RCD, "R5 row-to-column gap",
            logCyc[k] - logCyc[k-1], T_RCD);
    end
    @(negedge clk);
    if (!keepValid) check(!reqAck, "R6 ack one cycle", reqAck, 0);
  endtask

  task automatic testReset();
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = {2'd2, 12'hABC, 8'h5A};
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(!cke && csN && !reqAck && !initDone, "R1 reset outputs",
          {cke, csN, reqAck, initDone}, 4'b0100);
    rstN = 1'b1;
  endtask

  task automatic testInit();
    int rel = cyc;
    int n = 0;
    while (!initDone && n < 500) begin @(negedge clk); n++; end
    #1;
    check(initDone, "R3 initDone reached", initDone, 1);
    check(ackTotal == 0, "R10 no ack before initDone", ackTotal, 0);
    check(logCyc[0] - rel >= INIT_WAIT, "R1 power-up NOP span", logCyc[0] - rel, INIT_WAIT);
    check(logK[0] == K_PRE && logA[0][10], "R3 precharge all", {logK[0], logA[0][10]}, {K_PRE, 1'b1});
    check(logK[1] == K_REF && logCyc[1] - logCyc[0] == T_RP, "R3 first refresh",
          logCyc[1] - logCyc[0], T_RP);
    check(logK[2] == K_REF && logCyc[2] - logCyc[1] == T_RFC, "R3 second refresh",
          logCyc[2] - logCyc[1], T_RFC);
    check(logK[3] == K_MRS && logCyc[3] - logCyc[2] == T_RFC, "R3 mode load position",
          logCyc[3] - logCyc[2], T_RFC);
    check(logA[3] == MODE && logBa[3] == 2'd0, "R3 mode operand", logA[3], MODE);
    check(cyc - logCyc[3] >= T_MRD, "R4 initDone after mode gap", cyc - logCyc[3], T_MRD);
    // R10: the request held since reset is served now
    awaitAck(1'b1, {2'd2, 12'hABC, 8'h5A}, 1'b0, '0);
  endtask

  task automatic testAccess(input bit wr, input logic [21:0] a);
    repeat (2) @(negedge clk);
    reqWrite = wr; reqAddr = a; reqValid = 1'b1;
    awaitAck(wr, a, 1'b0, '0);
  endtask

  task automatic testIdleRefresh();
    int start = nLog;
    int refs[8];
    int nr = 0;
    repeat (4 * REF_INT + 20) @(negedge clk);
    for (int i = start; i < nLog; i++)
      if (logK[i] == K_REF && nr < 8) begin refs[nr] = logCyc[i]; nr++; end
    check(nr >= 4, "R9 idle refresh count", nr, 4);
    for (int i = 1; i + 1 < nr; i++)
      check(refs[i+1] - refs[i] == REF_INT, "R9 idle refresh period", refs[i+1] - refs[i], REF_INT);
  endtask

  task automatic testStream();
    int start = nLog;
    logic [21:0] a = {2'd0, 12'h001, 8'h10};
    reqWrite = 1'b0; reqAddr = a; reqValid = 1'b1;
    for (int s = 0; s < 16; s++) begin
      logic [21:0] nxt = {a[21:20] + 2'd1, a[19:8] + 12'h011, a[7:0] + 8'h07};
      awaitAck(1'b0, a, s != 15, nxt);
      a = nxt;
    end
    reqValid = 1'b0;
    begin
      int nr = 0;
      for (int i = start; i < nLog; i++) if (logK[i] == K_REF) nr++;
      check(nr >= 1, "R9 refresh within request stream", nr, 1);
    end
  endtask

  task automatic scanLog();
    int lastRef = -1;
    int worst = 0;
    int lastAct = -1;
    int bad4 = 0, bad7 = 0, bad8 = 0;
    for (int i = 4; i < nLog; i++) begin
      if (logK[i] == K_REF) begin
        if (lastRef >= 0 && logCyc[i] - lastRef > worst) worst = logCyc[i] - lastRef;
        lastRef = logCyc[i];
      end
    end
    for (int i = 1; i < nLog; i++) begin
      int g = logCyc[i] - logCyc[i-1];
      if (logK[i-1] == K_MRS && g < T_MRD) bad4++;
      if (logK[i-1] == K_REF && g < T_RFC) bad8++;
      if ((logK[i] == K_ACT || logK[i] == K_REF) && lastAct >= 0 && logCyc[i] - lastAct < T_RC) bad7++;
      if (logK[i] == K_ACT) lastAct = logCyc[i];
    end
    check(bad4 == 0, "R4 mode-load spacing", bad4, 0);
    check(bad8 == 0, "R8 refresh spacing", bad8, 0);
    check(bad7 == 0, "R7 row cycle spacing", bad7, 0);
    check(worst <= REF_INT + T_RC, "R9 worst refresh gap", worst, REF_INT + T_RC);
    check(strayAck == 0, "R6 ack only with column cmd", strayAck, 0);
    check(ckeLow == 0, "R2 cke high on commands", ckeLow, 0);
    check(nLog < LOG_N, "R2 log capacity", nLog, LOG_N);
  endtask

  initial begin
    testReset();
    testInit();
    testAccess(1'b0, {2'd1, 12'h123, 8'hFF});
    testAccess(1'b1, {2'd3, 12'hFFF, 8'h00});
    testIdleRefresh();
    testStream();
    repeat (20) @(negedge clk);
    scanLog();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule